// File: doc/BRIEF.md
# Cache ECC Error Recovery Controller

This block runs the repair sequence that follows an ECC error reported by a level-one cache lookup. A lookup that finds an error presents a one-cycle report. The report carries the error class (single or double bit), the array that held the bad bits, whether the line is dirty, whether the lookup was in the instruction or the data cache, and whether a coherency-maintenance port issued the request. It also carries the line index and a per-byte map of the bytes that hold a double-bit error. From the report the controller chooses a path through write-back, invalidate, refill and access retry. It drives the write-back and refill handshakes and sets the byte strobes of the write-back.

A 3-bit mode field selects whether checking is on, whether errors abort the faulting access, and whether write-back write-allocate memory is forced to write-through. That last setting keeps lines from ever turning dirty. It is brought out as a level for the cache's allocation logic. A single state machine runs the sequence and accepts a new report only while idle.

Top module: `ecc_recovery_ctrl`

## Requirements
- R1: Mode decode. Checking is on for codes 000, 001, 010, 101 and 110. Aborts on correctable errors are enabled for 000, 001 and 010. `force_wt` is 1 exactly for 001, 010 and 110.
- R2: With mode 100, or a reserved code (011, 111), an error report is ignored. `busy` and `err_event` stay 0 and `fault_index` keeps its value.
- R3: A report is taken only while `busy` is 0. Reports and changes to report fields while busy have no effect on the running sequence, on `fault_index` or on `err_event`.
- R4: In the cycle after a report is accepted, `busy` is 1, `err_event` pulses for exactly that one cycle, and `fault_index` holds the reported index.
- R5: A clean data-cache line, or any instruction-cache line, is recovered without a write-back: one invalidate, then a refill.
- R6: A dirty data-cache line with a single-bit error is written back with all strobes set. `wb_req` is held until `wb_ack`, and the invalidate and the refill follow.
- R7: A double-bit error in the data array (`err_ram` 10 or 11) of a dirty data-cache line is still written back. `wb_strb[i]` is 0 exactly where `err_bad_bytes[i]` is 1.
- R8: A double-bit error in the tag array (`err_ram` 00) or dirty array (`err_ram` 01) of a dirty data-cache line issues no write-back. The line is invalidated and refilled.
- R9: A double-bit error in a dirty data-cache line is uncorrectable. It always raises `access_abort` as a one-cycle pulse, with `busy` already 0, in any enabled mode and for any requester.
- R10: A correctable error raises `access_abort` only when aborts are enabled and the request did not come from the coherency port. In that case no retry is issued.
- R11: Every recovery that raises no abort ends with a one-cycle `access_retry` after the refill completes.
- R12: Only one of `wb_req`, `inv_req`, `rf_req`, `access_retry` is high in any cycle. `inv_req` lasts one cycle and is followed by `rf_req`, which is held until `rf_ack`. The order is write-back, then invalidate, then refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Error-handling mode code |
| force_wt | output | 1 | Treat write-back write-allocate memory as write-through |
| err_valid | input | 1 | Error report strobe |
| err_double | input | 1 | 1: double-bit error, 0: single-bit |
| err_ram | input | 2 | Array holding the error: 00 tag, 01 dirty, 10/11 data |
| err_dirty | input | 1 | Line is dirty |
| err_icache | input | 1 | Error is in the instruction cache |
| err_coherency | input | 1 | Request came from the coherency-maintenance port |
| err_index | input | IDX_W | Line index of the failing line |
| err_bad_bytes | input | LINE_BYTES | Bytes holding a double-bit data error |
| busy | output | 1 | Recovery in progress |
| err_event | output | 1 | One-cycle pulse per accepted error |
| fault_index | output | IDX_W | Index of the last accepted error |
| wb_req | output | 1 | Write-back request |
| wb_index | output | IDX_W | Line written back |
| wb_strb | output | LINE_BYTES | Per-byte write strobes |
| wb_ack | input | 1 | Write-back accepted |
| inv_req | output | 1 | One-cycle invalidate command |
| inv_index | output | IDX_W | Line to invalidate |
| rf_req | output | 1 | Refill request |
| rf_index | output | IDX_W | Line to refill |
| rf_ack | input | 1 | Refill complete |
| access_retry | output | 1 | Replay the original access |
| access_abort | output | 1 | Abort the original access |

## Verification
A wrong state register shows at the ports within one cycle. The request line of the step that is running is wrong, or two request lines are high together, or `busy` disagrees with the handshake. A wrongly latched classification shows later. It appears when the write-back is skipped or issued, in the strobe pattern, or in the choice between abort and retry, which comes in the cycle after the refill acknowledge. The bench sweeps every mode against every report combination with varied acknowledge delays. It changes the report fields after acceptance, so a design that reads them live gives itself away at the ports.

// File: rtl/ecc_recovery_pkg.sv
package ecc_recovery_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_EVICT  = 3'd1,
    ST_INVAL  = 3'd2,
    ST_REFILL = 3'd3,
    ST_RETRY  = 3'd4
  } rec_state_e;

  localparam logic [1:0] RAM_TAG   = 2'b00;
  localparam logic [1:0] RAM_DIRTY = 2'b01;

  typedef struct packed {
    logic       dbl;
    logic [1:0] ram;
    logic       dirty;
    logic       icache;
    logic       coh;
  } err_info_t;

  typedef struct packed {
    logic chk_en;
    logic abort_en;
    logic force_wt;
  } mode_cfg_t;

  typedef struct packed {
    logic do_wb;
    logic unc;
    logic need_abort;
    logic mask_bad;
  } err_class_t;

endpackage

// File: rtl/ecc_mode_decode.sv
module ecc_mode_decode
  import ecc_recovery_pkg::*;
(
  input  logic [2:0] mode,
  output mode_cfg_t  cfg
);

  always_comb begin
    cfg = '0;
    unique case (mode)
      3'b000: begin cfg.chk_en = 1'b1; cfg.abort_en = 1'b1; end
      3'b001,
      3'b010: begin cfg.chk_en = 1'b1; cfg.abort_en = 1'b1; cfg.force_wt = 1'b1; end
      3'b101: begin cfg.chk_en = 1'b1; end
      3'b110: begin cfg.chk_en = 1'b1; cfg.force_wt = 1'b1; end
      default: cfg = '0;  // 100 off, 011/111 reserved: treated as off
    endcase
  end

endmodule

// File: rtl/ecc_error_classify.sv
module ecc_error_classify
  import ecc_recovery_pkg::*;
(
  input  err_info_t  info,
  input  logic       abort_en,
  output err_class_t cls
);

  logic dirty_eff;
  logic meta_ram;

  always_comb begin
    // instruction lines never hold modified data
    dirty_eff      = info.dirty & ~info.icache;
    meta_ram       = (info.ram == RAM_TAG) || (info.ram == RAM_DIRTY);
    cls.unc        = info.dbl & dirty_eff;
    cls.do_wb      = dirty_eff & ~(cls.unc & meta_ram);
    cls.mask_bad   = cls.unc & ~meta_ram;
    cls.need_abort = cls.unc | (abort_en & ~info.coh);
  end

endmodule

// File: rtl/ecc_evict_strobe.sv
module ecc_evict_strobe #(
  parameter int LINE_BYTES = 8
) (
  input  logic                  mask_en,
  input  logic [LINE_BYTES-1:0] bad_bytes,
  output logic [LINE_BYTES-1:0] strb
);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign strb[b] = ~(mask_en & bad_bytes[b]);
  end

endmodule

// File: rtl/ecc_recovery_fsm.sv
module ecc_recovery_fsm
  import ecc_recovery_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int LINE_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  err_valid,
  input  logic                  chk_en,
  input  err_class_t            cls,
  input  logic [IDX_W-1:0]      err_index,
  input  logic [LINE_BYTES-1:0] err_bad_bytes,
  input  logic                  wb_ack,
  input  logic                  rf_ack,
  output rec_state_e            state,
  output logic [IDX_W-1:0]      idx_q,
  output logic [LINE_BYTES-1:0] bad_q,
  output logic                  mask_q,
  output logic                  event_q,
  output logic                  abort_q
);

  rec_state_e state_nxt;
  logic       accept;
  logic       need_abort_q;
  logic       abort_set;

  assign accept    = (state == ST_IDLE) && err_valid && chk_en;
  assign abort_set = (state == ST_REFILL) && rf_ack && need_abort_q;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:   if (accept) state_nxt = cls.do_wb ? ST_EVICT : ST_INVAL;
      ST_EVICT:  if (wb_ack) state_nxt = ST_INVAL;
      ST_INVAL:  state_nxt = ST_REFILL;
      ST_REFILL: if (rf_ack) state_nxt = need_abort_q ? ST_IDLE : ST_RETRY;
      ST_RETRY:  state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nxt;
    end
  end

  // report capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q        <= '0;
      bad_q        <= '0;
      mask_q       <= 1'b0;
      need_abort_q <= 1'b0;
    end else if (accept) begin
      idx_q        <= err_index;
      bad_q        <= err_bad_bytes;
      mask_q       <= cls.mask_bad;
      need_abort_q <= cls.need_abort;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      event_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      event_q <= accept;
      abort_q <= abort_set;
    end
  end

endmodule

// File: rtl/ecc_recovery_ctrl.sv
module ecc_recovery_ctrl
  import ecc_recovery_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int LINE_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            cfg_mode,
  output logic                  force_wt,
  input  logic                  err_valid,
  input  logic                  err_double,
  input  logic [1:0]            err_ram,
  input  logic                  err_dirty,
  input  logic                  err_icache,
  input  logic                  err_coherency,
  input  logic [IDX_W-1:0]      err_index,
  input  logic [LINE_BYTES-1:0] err_bad_bytes,
  output logic                  busy,
  output logic                  err_event,
  output logic [IDX_W-1:0]      fault_index,
  output logic                  wb_req,
  output logic [IDX_W-1:0]      wb_index,
  output logic [LINE_BYTES-1:0] wb_strb,
  input  logic                  wb_ack,
  output logic                  inv_req,
  output logic [IDX_W-1:0]      inv_index,
  output logic                  rf_req,
  output logic [IDX_W-1:0]      rf_index,
  input  logic                  rf_ack,
  output logic                  access_retry,
  output logic                  access_abort
);

  mode_cfg_t             cfg;
  err_info_t             info;
  err_class_t            cls;
  rec_state_e            state;
  logic [IDX_W-1:0]      idx_q;
  logic [LINE_BYTES-1:0] bad_q;
  logic                  mask_q;
  logic                  event_q;
  logic                  abort_q;

  assign info.dbl    = err_double;
  assign info.ram    = err_ram;
  assign info.dirty  = err_dirty;
  assign info.icache = err_icache;
  assign info.coh    = err_coherency;

  ecc_mode_decode u_mode (
    .mode (cfg_mode),
    .cfg  (cfg)
  );

  ecc_error_classify u_class (
    .info     (info),
    .abort_en (cfg.abort_en),
    .cls      (cls)
  );

  ecc_recovery_fsm #(
    .IDX_W      (IDX_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_valid     (err_valid),
    .chk_en        (cfg.chk_en),
    .cls           (cls),
    .err_index     (err_index),
    .err_bad_bytes (err_bad_bytes),
    .wb_ack        (wb_ack),
    .rf_ack        (rf_ack),
    .state         (state),
    .idx_q         (idx_q),
    .bad_q         (bad_q),
    .mask_q        (mask_q),
    .event_q       (event_q),
    .abort_q       (abort_q)
  );

  ecc_evict_strobe #(
    .LINE_BYTES (LINE_BYTES)
  ) u_strb (
    .mask_en   (mask_q),
    .bad_bytes (bad_q),
    .strb      (wb_strb)
  );

  assign force_wt     = cfg.force_wt;
  assign busy         = (state != ST_IDLE);
  assign err_event    = event_q;
  assign fault_index  = idx_q;
  assign wb_req       = (state == ST_EVICT);
  assign inv_req      = (state == ST_INVAL);
  assign rf_req       = (state == ST_REFILL);
  assign access_retry = (state == ST_RETRY);
  assign access_abort = abort_q;
  assign wb_index     = idx_q;
  assign inv_index    = idx_q;
  assign rf_index     = idx_q;

endmodule

// File: rtl/ecc_recovery_checker.sv
module ecc_recovery_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cfg_mode,
  input logic       err_valid,
  input logic       busy,
  input logic       err_event,
  input logic       wb_req,
  input logic       wb_ack,
  input logic       inv_req,
  input logic       rf_req,
  input logic       rf_ack,
  input logic       access_retry,
  input logic       access_abort
);

  logic mode_on;
  assign mode_on = (cfg_mode == 3'b000) || (cfg_mode == 3'b001) ||
                   (cfg_mode == 3'b010) || (cfg_mode == 3'b101) ||
                   (cfg_mode == 3'b110);

  p_one_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_req, inv_req, rf_req, access_retry}));

  p_wb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req);

  p_rf_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req && !rf_ack |=> rf_req);

  p_inv_then_refill_r12: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |=> rf_req && !inv_req);

  p_ignore_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && err_valid && !mode_on |=> !busy && !err_event);

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && err_valid && mode_on |=> busy && err_event);

  p_single_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> !err_event);

  p_retry_no_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    access_retry |=> !access_abort);

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    access_abort |-> !busy && !access_retry);

endmodule

bind ecc_recovery_ctrl ecc_recovery_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mode     (cfg_mode),
  .err_valid    (err_valid),
  .busy         (busy),
  .err_event    (err_event),
  .wb_req       (wb_req),
  .wb_ack       (wb_ack),
  .inv_req      (inv_req),
  .rf_req       (rf_req),
  .rf_ack       (rf_ack),
  .access_retry (access_retry),
  .access_abort (access_abort)
);

// File: tb/ecc_recovery_ctrl_bench.sv
`timescale 1ns/1ps
module ecc_recovery_ctrl_bench;

  localparam int IDX_W = 6;
  localparam int LB    = 8;

  logic          clk;
  logic          rst_n;
  logic [2:0]    cfg_mode;
  logic          force_wt;
  logic          err_valid, err_double, err_dirty, err_icache, err_coherency;
  logic [1:0]    err_ram;
  logic [IDX_W-1:0] err_index;
  logic [LB-1:0] err_bad_bytes;
  logic          busy, err_event;
  logic [IDX_W-1:0] fault_index, wb_index, inv_index, rf_index;
  logic          wb_req, wb_ack, inv_req, rf_req, rf_ack;
  logic [LB-1:0] wb_strb;
  logic          access_retry, access_abort;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  logic [IDX_W-1:0] prev_fault;

  ecc_recovery_ctrl #(.IDX_W(IDX_W), .LINE_BYTES(LB)) u_ecc_recovery_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .force_wt(force_wt),
    .err_valid(err_valid), .err_double(err_double), .err_ram(err_ram),
    .err_dirty(err_dirty), .err_icache(err_icache), .err_coherency(err_coherency),
    .err_index(err_index), .err_bad_bytes(err_bad_bytes),
    .busy(busy), .err_event(err_event), .fault_index(fault_index),
    .wb_req(wb_req), .wb_index(wb_index), .wb_strb(wb_strb), .wb_ack(wb_ack),
    .inv_req(inv_req), .inv_index(inv_index),
    .rf_req(rf_req), .rf_index(rf_index), .rf_ack(rf_ack),
    .access_retry(access_retry), .access_abort(access_abort)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int mode, input int dbl, input int ram, input int dirty,
                          input int ic, input int coh, input int idx, input int bad,
                          input int wdly, input int rdly);
    bit on, aen, fwt, deff, unc, do_wb, exp_abort, done;
    int exp_strb, strb_got, wb_cycles, inv_cnt, rf_seen, retry_cnt, abort_cnt, ev_extra;
    int wb_pos, inv_pos, rf_pos, wcnt, rcnt;
    on   = (mode == 0) || (mode == 1) || (mode == 2) || (mode == 5) || (mode == 6);
    aen  = (mode <= 2);
    fwt  = (mode == 1) || (mode == 2) || (mode == 6);
    deff = (dirty != 0) && (ic == 0);
    unc  = (dbl != 0) && deff;
    do_wb = deff && !(unc && ram < 2);
    exp_strb  = (unc && ram >= 2) ? (~bad & 8'hFF) : 8'hFF;
    exp_abort = unc || (aen && coh == 0);

    cfg_mode = 3'(mode);
    #0.1;
    chk(force_wt == fwt, "R1 force_wt", int'(force_wt), int'(fwt));
    err_valid = 1'b1; err_double = dbl[0]; err_ram = 2'(ram); err_dirty = dirty[0];
    err_icache = ic[0]; err_coherency = coh[0];
    err_index = IDX_W'(idx); err_bad_bytes = LB'(bad);
    @(posedge clk); @(negedge clk);
    // R3: alter report fields while busy; err_valid stays high
    err_index = ~IDX_W'(idx); err_bad_bytes = ~LB'(bad);
    if (!on) begin
      chk(busy == 0, "R2 busy", int'(busy), 0);
      chk(err_event == 0, "R2 event", int'(err_event), 0);
      chk(fault_index == prev_fault, "R2 fault_index", int'(fault_index), int'(prev_fault));
      err_valid = 1'b0;
      return;
    end
    chk(busy == 1 && err_event == 1, "R4 accept", int'({busy, err_event}), 3);
    chk(fault_index == IDX_W'(idx), "R4 fault_index", int'(fault_index), idx);
    done = 0; strb_got = 0; wb_cycles = 0; inv_cnt = 0; rf_seen = 0;
    retry_cnt = 0; abort_cnt = 0; ev_extra = 0;
    wb_pos = -1; inv_pos = -1; rf_pos = -1; wcnt = 0; rcnt = 0;
    for (int c = 0; c < 60; c++) begin
      if (err_event && c > 0) ev_extra++;
      if (wb_req) begin
        if (wb_pos < 0) wb_pos = c;
        wb_cycles++;
        strb_got = int'(wb_strb);
        wb_ack = (wcnt == wdly);
        wcnt++;
      end else wb_ack = 1'b0;
      if (inv_req) begin inv_cnt++; inv_pos = c; end
      if (rf_req) begin
        if (rf_pos < 0) rf_pos = c;
        rf_seen = 1;
        rf_ack = (rcnt == rdly);
        rcnt++;
      end else rf_ack = 1'b0;
      if (access_retry) retry_cnt++;
      if (access_abort) abort_cnt++;
      if (!busy) begin done = 1; break; end
      @(posedge clk); @(negedge clk);
    end
    err_valid = 1'b0; wb_ack = 1'b0; rf_ack = 1'b0;
    chk(done, "R12 completes", int'(done), 1);
    chk(ev_extra == 0, "R3 no extra event", ev_extra, 0);
    chk(fault_index == IDX_W'(idx), "R3 fault_index held", int'(fault_index), idx);
    if (!deff) chk(wb_cycles == 0, "R5 no write-back", wb_cycles, 0);
    else if (!do_wb) chk(wb_cycles == 0, "R8 no write-back", wb_cycles, 0);
    else chk(wb_cycles == wdly + 1, "R6 write-back held to ack", wb_cycles, wdly + 1);
    if (do_wb) begin
      if (unc) chk(strb_got == exp_strb, "R7 strobes", strb_got, exp_strb);
      else chk(strb_got == exp_strb, "R6 strobes", strb_got, exp_strb);
    end
    chk(inv_cnt == 1 && rf_seen == 1, "R5 invalidate and refill", inv_cnt * 2 + rf_seen, 3);
    chk(inv_pos + 1 == rf_pos && (!do_wb || wb_pos < inv_pos), "R12 order",
        rf_pos - inv_pos, 1);
    if (unc) chk(abort_cnt == 1, "R9 abort", abort_cnt, 1);
    else chk(abort_cnt == int'(exp_abort), "R10 abort", abort_cnt, int'(exp_abort));
    chk(retry_cnt == int'(!exp_abort), "R11 retry", retry_cnt, int'(!exp_abort));
    @(posedge clk); @(negedge clk);
    chk(access_abort == 0 && busy == 0 && access_retry == 0, "R9 pulse ends",
        int'({access_abort, busy, access_retry}), 0);
    prev_fault = IDX_W'(idx);
  endtask

  initial begin
    rst_n = 1'b0; cfg_mode = 3'b000; err_valid = 1'b0; err_double = 1'b0;
    err_ram = 2'b00; err_dirty = 1'b0; err_icache = 1'b0; err_coherency = 1'b0;
    err_index = '0; err_bad_bytes = '0; wb_ack = 1'b0; rf_ack = 1'b0;
    prev_fault = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && err_event == 0 && wb_req == 0 && inv_req == 0 && rf_req == 0 &&
        access_retry == 0 && access_abort == 0, "R4 reset outputs", int'(busy), 0);
    chk(fault_index == 0, "R4 reset fault_index", int'(fault_index), 0);
    rst_n = 1'b1;
    @(negedge clk);
    begin
      int n;
      n = 0;
      for (int m = 0; m < 8; m++)
        for (int d = 0; d < 2; d++)
          for (int r = 0; r < 3; r++)
            for (int dt = 0; dt < 2; dt++)
              for (int ic = 0; ic < 2; ic++)
                for (int co = 0; co < 2; co++) begin
                  run_case(m, d, r, dt, ic, co, (n * 7 + 3) % 64,
                           ((n * 37 + 5) % 255) + 1, n % 3, (n / 3) % 3);
                  @(negedge clk);
                  n++;
                end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule